// File: doc/BRIEF.md
# I2C Byte Master Controller

This block is a register-driven I2C bus master that moves one byte for each CPU access to its data register. While the master-enable input is high, software writes a byte to send it when the direction bit selects transmit. When the direction bit selects receive, a read of the data register fetches the next byte from the target. The first byte written after master enable goes high is the address byte: a 7-bit target address in bits 7..1 and the read/write flag in bit 0. It is shifted out unchanged, as the first byte after the START condition.

Raising master enable puts a START on the bus. Lowering it puts a STOP on the bus, but only after any byte already in flight has completed. Each byte takes nine SCL clocks. The ninth clock either samples the target's acknowledge or drives the master's own acknowledge. A sticky transfer-complete flag tells software when the byte has finished.

Bus timing comes from a quarter-period divider. One SCL period has four quarters of `quarter_div`+1 system clocks each. Both bus lines are open drain: an output-enable of 1 pulls the line low, and 0 releases it. SCL is driven only and is never sampled.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `rdata` is 0x00, and `busy`, `done`, `scl_oe` and `sda_oe` are all 0.
- R2: When `master_en` is high while the bus is idle, a START is issued: SDA falls while SCL is high, then SCL is pulled low. `busy` is high from then on.
- R3: A `wr_stb` pulse while `master_en`=1 and `tx_dir`=1 sends `wdata` as eight data bits, bit 7 first, each stable while SCL is high. The first such byte after START is the address byte (address in bits 7..1, R/W in bit 0) and goes out unchanged.
- R4: On the ninth clock of a transmit byte the master releases SDA. `ack_seen` takes the value 1 if SDA was low at that clock and 0 if it was high.
- R5: An `rd_stb` pulse while `master_en`=1 and `tx_dir`=0 receives eight bits, bit 7 first, into the data register. On the ninth clock the master drives SDA low when `no_ack`=0 and leaves SDA released when `no_ack`=1.
- R6: A data-register access starts no byte if the direction does not match or if `master_en`=0. This covers an `rd_stb` with `tx_dir`=1, a `wr_stb` with `tx_dir`=0, and a final read made after master mode has been left.
- R7: `rdata` always shows the last byte received. Writes never change it.
- R8: `done` sets at the end of the ninth clock of each byte. It stays set until a `done_clr` pulse, which clears it on the next clock.
- R9: When `master_en` falls, a STOP is issued (SDA rises while SCL is high) once the current byte has completed. `busy` returns to 0 after the STOP.
- R10: During a byte, each SCL period is 4×(`quarter_div`+1) clocks. SDA changes only while SCL is low, except at START and STOP.
- R11: Data-register accesses made while a byte is being shifted are ignored, so no second byte is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_div | input | DIV_W | Length of one SCL quarter, minus one, in clocks |
| master_en | input | 1 | Master mode enable; a rise issues START, a fall issues STOP |
| tx_dir | input | 1 | 1 = transmit, 0 = receive |
| no_ack | input | 1 | 1 = do not acknowledge received bytes |
| wr_stb | input | 1 | CPU write strobe for the data register |
| rd_stb | input | 1 | CPU read strobe for the data register |
| wdata | input | 8 | Byte written by the CPU |
| rdata | output | 8 | Last byte received |
| done_clr | input | 1 | Write-one-to-clear pulse for `done` |
| busy | output | 1 | Bus owned, from START until the end of STOP |
| done | output | 1 | Sticky byte-complete flag |
| ack_seen | output | 1 | Acknowledge sampled on the last transmit byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A wrong quarter counter or phase value shows at the bus pins within one quarter: SDA moves while SCL is high, or the SCL period is the wrong length. A corrupted bit index or shift register shows as a wrong byte, or a wrong ninth-clock level, at the bench's bus target within one byte time of 36 quarters. A pending-start flag that is set wrongly shows as an extra byte on the bus during the quiet window that follows a rejected access. A state machine that leaves the wait state too early or too late shows as a STOP that cuts off the byte, or one that never arrives.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             master_en,
  input  logic             tx_dir,
  input  logic             no_ack,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             done_clr,
  output logic             busy,
  output logic             done,
  output logic             ack_seen,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_WAIT, S_BIT, S_STOP} st_t;

  localparam logic [3:0] LAST_BIT = 4'd8;

  st_t             st;
  logic [DIV_W-1:0] cnt;
  logic [1:0]       ph;
  logic [3:0]       idx;
  logic [7:0]       sh, rx_q;
  logic             go, go_rx, xrx, xnack;

  wire run    = (st == S_START) || (st == S_BIT) || (st == S_STOP);
  wire tick   = run && (cnt == quarter_div);
  wire last_q = tick && (ph == 2'd3);
  wire can_go = master_en && !go && (st != S_BIT);
  wire take_w = wr_stb && tx_dir && can_go;
  wire take_r = rd_stb && !tx_dir && can_go;

  assign rdata = rx_q;
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ph       <= 2'd0;
      idx      <= 4'd0;
      sh       <= 8'h00;
      rx_q     <= 8'h00;
      go       <= 1'b0;
      go_rx    <= 1'b0;
      xrx      <= 1'b0;
      xnack    <= 1'b0;
      done     <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      if (!run || tick) cnt <= '0;
      else              cnt <= cnt + 1'b1;
      if (!run)      ph <= 2'd0;
      else if (tick) ph <= ph + 2'd1;

      if (take_w) begin
        go    <= 1'b1;
        go_rx <= 1'b0;
        sh    <= wdata;
      end
      if (take_r) begin
        go    <= 1'b1;
        go_rx <= 1'b1;
      end
      if (done_clr) done <= 1'b0;

      case (st)
        S_IDLE:  if (master_en) st <= S_START;
        S_START: if (last_q) st <= S_WAIT;
        S_WAIT: begin
          if (go) begin
            st    <= S_BIT;
            go    <= 1'b0;
            xrx   <= go_rx;
            xnack <= no_ack;
            idx   <= 4'd0;
          end else if (!master_en) begin
            st <= S_STOP;
          end
        end
        S_BIT: begin
          if (tick && ph == 2'd2) begin
            if (xrx && idx < LAST_BIT)     sh       <= {sh[6:0], sda_in};
            if (!xrx && idx == LAST_BIT)   ack_seen <= !sda_in;
          end
          if (last_q) begin
            if (idx == LAST_BIT) begin
              st   <= S_WAIT;
              done <= 1'b1;
              if (xrx) rx_q <= sh;
            end else begin
              idx <= idx + 4'd1;
              if (!xrx) sh <= {sh[6:0], 1'b0};
            end
          end
        end
        S_STOP:  if (last_q) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (ph == 2'd3);
        sda_oe = ph[1];
      end
      S_WAIT: begin
        scl_oe = 1'b1;
        sda_oe = 1'b1;
      end
      S_BIT: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        if (idx == LAST_BIT) sda_oe = xrx && !xnack;
        else                 sda_oe = !xrx && !sh[7];
      end
      S_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = !ph[1];
      end
      default: ;
    endcase
  end

  // R10: SDA holds while SCL stays released inside a byte
  p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st == S_BIT) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  // R8: completion only follows the ninth clock of a byte
  p_done_after_ninth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st == S_BIT) && $past(idx == LAST_BIT)));

  // R9: STOP is only entered with master enable low
  p_stop_needs_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && $past(st == S_WAIT)) |-> !$past(master_en));

  // R6: a read in transmit direction never queues a byte
  p_read_in_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && tx_dir && !go) |=> !go);

  // R2: START only follows master enable
  p_start_from_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && $past(st == S_IDLE)) |-> $past(master_en));

  // R11: a byte in flight blocks any new launch request
  p_no_queue_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && !go) |=> !go);

endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  localparam int DIV  = 3;
  localparam int QCYC = DIV + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] quarter_div = 8'(DIV);
  logic       master_en = 0, tx_dir = 1, no_ack = 0;
  logic       wr_stb = 0, rd_stb = 0, done_clr = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       busy, done, ack_seen, scl_oe, sda_oe, sda_in;

  logic       slv_low = 1'b0;
  int         slv_mode = 0;
  logic       ack_en = 1'b0;
  logic [7:0] slv_byte = 8'h00;

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_low);
  assign sda_in = sda_line;

  i2c_byte_master #(.DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div), .master_en(master_en),
    .tx_dir(tx_dir), .no_ack(no_ack), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wdata(wdata), .rdata(rdata), .done_clr(done_clr), .busy(busy), .done(done),
    .ack_seen(ack_seen), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in));

  int total = 0, bad = 0;
  int cyc = 0;
  int starts = 0, stops = 0, nbytes = 0, bitn = 0;
  int t1 = 0, t2 = 0;
  logic [8:0] cap = 9'h0, last9 = 9'h0;

  always @(posedge clk) cyc++;

  always @(negedge sda_line) if (scl_line === 1'b1 && rst_n) begin starts++; bitn = 0; end
  always @(posedge sda_line) if (scl_line === 1'b1 && rst_n) stops++;
  always @(posedge scl_line) if (rst_n) begin
    cap = {cap[7:0], sda_line};
    if (bitn == 1) t1 = cyc;
    if (bitn == 2) t2 = cyc;
    bitn++;
    if (bitn == 9) begin last9 = cap; bitn = 0; nbytes++; end
  end
  always @(negedge scl_line) if (rst_n) begin
    if (slv_mode == 1)      slv_low = (bitn == 8) && ack_en;
    else if (slv_mode == 2) slv_low = (bitn < 8) ? ~slv_byte[7 - bitn] : 1'b0;
  end

  always @(posedge clk) if (cyc > 100000) begin
    total++; bad++;
    $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] v);
    @(negedge clk); wdata = v; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic do_rd();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk(done == 1'b0, "R8 done clears", int'(done), 0);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    chk(done == 1'b1, tag, int'(done), 1);
  endtask

  task automatic t_reset();
    chk(rdata == 8'h00, "R1 rdata", int'(rdata), 0);
    chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
    chk(!scl_oe && !sda_oe, "R1 bus released", int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic t_start();
    master_en = 1'b1;
    idle(30);
    chk(starts == 1, "R2 start seen", starts, 1);
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    chk(scl_oe == 1'b1, "R2 scl held low", int'(scl_oe), 1);
  endtask

  task automatic t_tx(input logic [7:0] v, input logic ack, input int exp_n);
    tx_dir = 1'b1; slv_mode = 1; ack_en = ack;
    do_wr(v);
    wait_done("R8 done after tx byte");
    chk(last9[8:1] == v, "R3 byte on bus", int'(last9[8:1]), int'(v));
    chk(ack_seen == ack, "R4 ack flag", int'(ack_seen), int'(ack));
    chk(nbytes == exp_n, "R3 byte count", nbytes, exp_n);
    slv_mode = 0; slv_low = 1'b0;
    clear_done();
  endtask

  task automatic t_rx(input logic [7:0] v, input logic nack, input int exp_n);
    tx_dir = 1'b0; no_ack = nack;
    slv_byte = v; slv_mode = 2; slv_low = ~v[7];
    do_rd();
    wait_done("R8 done after rx byte");
    chk(rdata == v, "R5 received byte", int'(rdata), int'(v));
    chk(last9[0] == nack, "R5 ninth clock level", int'(last9[0]), int'(nack));
    chk(nbytes == exp_n, "R5 byte count", nbytes, exp_n);
    slv_mode = 0; slv_low = 1'b0;
    clear_done();
  endtask

  task automatic t_timing();
    chk(t2 - t1 == 4 * QCYC, "R10 scl period", t2 - t1, 4 * QCYC);
  endtask

  task automatic t_wrong_rd(input int exp_n);
    tx_dir = 1'b1;
    do_rd();
    idle(400);
    chk(nbytes == exp_n, "R6 read in tx starts nothing", nbytes, exp_n);
    chk(done == 1'b0, "R6 no done", int'(done), 0);
  endtask

  task automatic t_wrong_wr(input int exp_n, input logic [7:0] keep);
    tx_dir = 1'b0;
    do_wr(8'hFF);
    idle(400);
    chk(nbytes == exp_n, "R6 write in rx starts nothing", nbytes, exp_n);
    chk(rdata == keep, "R7 write leaves rdata", int'(rdata), int'(keep));
  endtask

  task automatic t_busy_ignore(input int exp_n, input logic [7:0] keep);
    tx_dir = 1'b1; slv_mode = 1; ack_en = 1'b1;
    do_wr(8'h81);
    idle(40);
    do_wr(8'h7E);
    wait_done("R11 done");
    chk(last9[8:1] == 8'h81, "R11 first byte kept", int'(last9[8:1]), 'h81);
    slv_mode = 0; slv_low = 1'b0;
    clear_done();
    idle(400);
    chk(nbytes == exp_n, "R11 no queued byte", nbytes, exp_n);
    chk(rdata == keep, "R7 rdata after writes", int'(rdata), int'(keep));
  endtask

  task automatic t_leave_rx(input int exp_n, input logic [7:0] keep);
    tx_dir = 1'b0;
    master_en = 1'b0;
    do_rd();
    idle(200);
    chk(nbytes == exp_n, "R6 final read after leaving", nbytes, exp_n);
    chk(rdata == keep, "R7 last received", int'(rdata), int'(keep));
    chk(stops == 1, "R9 stop seen", stops, 1);
    chk(busy == 1'b0, "R9 busy low", int'(busy), 0);
  endtask

  task automatic t_stop_in_flight(input int exp_n);
    master_en = 1'b1;
    idle(30);
    chk(starts == 2, "R2 second start", starts, 2);
    tx_dir = 1'b1; slv_mode = 1; ack_en = 1'b1;
    do_wr(8'hC3);
    idle(40);
    master_en = 1'b0;
    idle(20);
    chk(busy == 1'b1 && stops == 1, "R9 stop waits for byte", stops, 1);
    wait_done("R9 byte completes");
    chk(last9[8:1] == 8'hC3, "R9 byte intact", int'(last9[8:1]), 'hC3);
    slv_mode = 0; slv_low = 1'b0;
    idle(60);
    chk(stops == 2, "R9 stop after byte", stops, 2);
    chk(busy == 1'b0, "R9 idle after stop", int'(busy), 0);
    chk(nbytes == exp_n, "R9 byte count", nbytes, exp_n);
    chk(starts == 2, "R10 no stray SDA edge", starts, 2);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_start();
    t_tx(8'hA4, 1'b1, 1);
    t_tx(8'h3C, 1'b0, 2);
    t_timing();
    t_wrong_rd(2);
    t_rx(8'h96, 1'b0, 3);
    t_rx(8'h5A, 1'b1, 4);
    t_wrong_wr(4, 8'h5A);
    t_busy_ignore(5, 8'h5A);
    t_leave_rx(5, 8'h5A);
    t_stop_in_flight(6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule